// File: doc/BRIEF.md
# Phase-Offset XOR Pulse-Width Generator

This block makes several pulse-width-modulated lines from pairs of square waves of equal frequency. One master phase accumulator runs for the whole life of the block. Every channel keeps a slave accumulator that advances by the same increment. The duty cycle of a channel is set by how far its slave phase leads the master phase. The channel output is the exclusive-OR of the two most significant bits. The duty cycle therefore covers the whole range from always low to always high, in steps of one clock.

Software acts only when a duty cycle changes. It places the new phase lead on a channel's offset input and pulses that channel's load strobe for one clock. The slave accumulator is then rewritten so that it stands exactly that lead ahead of the master. It then runs on by itself, and no further writes are needed. For jitter-free edges the increment should divide 2^32 evenly, which makes the master period a power of two in clocks (for example 256 or 128).

Top module: `xpwm_gen`

## Requirements
- R1: While `rst` is high, all accumulators are cleared, every `pwm_out` bit and `master_wave` are low, and `freq_inc` is captured as the running increment.
- R2: After reset, the master accumulator advances by the captured increment on every clock and is never reloaded. Changes on `freq_inc` while `rst` is low have no effect. `master_wave` is the master accumulator's bit 31, so with increment 2^24 it is high for exactly 128 of every 256 clocks.
- R3: A clock edge that samples `load_en[i]` high rewrites slave `i` so that, right after that edge, slave minus master equals `phase_off[i*32 +: 32]`. From the cycle after that edge, the channel's output follows the new offset.
- R4: While `load_en[i]` is low, the difference between slave `i` and the master stays constant (modulo 2^32), so the output waveform repeats without intervention.
- R5: Once a channel has been loaded, `pwm_out[i]` equals `master_wave` XOR bit 31 of slave `i`. The output repeats every half master period. For an offset D (modulo 2^32), the output is high for a fraction min(D, 2^32-D)/2^31 of the time. With increment 2^24, an offset of k*2^24 for k in 0..128 gives 2k high clocks in every 256.
- R6: An offset of 0 holds the output constantly low, and an offset of 2^31 holds it constantly high.
- R7: A channel that has not been loaded since reset keeps its output low.
- R8: A load on one channel does not change the output of any other channel.
- R9: A reload while the channel is running takes effect at a single clock edge, with no intermediate waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures `freq_inc` |
| freq_inc | input | 32 | Phase increment shared by master and all slaves |
| phase_off | input | NUM_CH*32 | Per-channel phase lead; channel i at bits i*32 +: 32 |
| load_en | input | NUM_CH | Per-channel one-clock update strobe |
| pwm_out | output | NUM_CH | Pulse-width-modulated outputs |
| master_wave | output | 1 | Master square wave (bit 31 of master accumulator) |

## Verification
A slave accumulator that drifts from its loaded lead shows up at once as a wrong duty cycle on its own line, and the drift is visible at the first edge after it occurs. A master accumulator that steps wrongly or is reloaded disturbs `master_wave` and every loaded channel within half a master period. A lost or misplaced reload shows at the first edge where the old and new waveforms differ. This is why the bench compares every output on every clock against an independently stepped phase model. It also counts high clocks over whole periods for the limiting offsets: zero, one clock, a quarter, just under half, exactly half, and beyond half.

// File: rtl/xpwm_pkg.sv
package xpwm_pkg;

    localparam int unsigned XP_ACC_W = 32;

    typedef logic [XP_ACC_W-1:0] phase_t;

    typedef struct packed {
        phase_t acc;
        logic   armed;
    } slave_t;

    function automatic logic wave_of(input phase_t p);
        return p[XP_ACC_W-1];
    endfunction

    // Slave phase that sits exactly `lead` ahead of the master after the edge.
    function automatic phase_t aligned_phase(input phase_t master_now,
                                             input phase_t step,
                                             input phase_t lead);
        return master_now + step + lead;
    endfunction

endpackage

// File: rtl/xpwm_master_nco.sv
module xpwm_master_nco
    import xpwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t freq_inc,
    output phase_t step,
    output phase_t acc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            step <= freq_inc;
        end else begin
            acc  <= acc + step;
        end
    end

    // R2
    step_locked_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(step));

endmodule

// File: rtl/xpwm_slave_nco.sv
module xpwm_slave_nco
    import xpwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t step,
    input  phase_t master_acc,
    input  phase_t lead,
    input  logic   load,
    output slave_t st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st.acc   <= '0;
            st.armed <= 1'b0;
        end else if (load) begin
            st.acc   <= aligned_phase(master_acc, step, lead);
            st.armed <= 1'b1;
        end else begin
            st.acc   <= st.acc + step;
        end
    end

    // R3
    load_align_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (phase_t'(st.acc - master_acc) == $past(lead)));

    // R4
    lead_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && st.armed) |=>
            (phase_t'(st.acc - master_acc) == $past(phase_t'(st.acc - master_acc))));

endmodule

// File: rtl/xpwm_xor_comb.sv
module xpwm_xor_comb
    import xpwm_pkg::*;
(
    input  phase_t master_acc,
    input  slave_t st,
    output logic   pwm
);

    always_comb begin
        pwm = st.armed & (wave_of(master_acc) ^ wave_of(st.acc));
    end

endmodule

// File: rtl/xpwm_gen.sv
module xpwm_gen
    import xpwm_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [XP_ACC_W-1:0]          freq_inc,
    input  logic [NUM_CH*XP_ACC_W-1:0]   phase_off,
    input  logic [NUM_CH-1:0]            load_en,
    output logic [NUM_CH-1:0]            pwm_out,
    output logic                         master_wave
);

    localparam int unsigned W = XP_ACC_W;

    phase_t master_acc;
    phase_t step;
    slave_t slv [NUM_CH];

    xpwm_master_nco u_master (
        .clk      (clk),
        .rst      (rst),
        .freq_inc (freq_inc),
        .step     (step),
        .acc      (master_acc)
    );

    assign master_wave = wave_of(master_acc);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        xpwm_slave_nco u_slave (
            .clk        (clk),
            .rst        (rst),
            .step       (step),
            .master_acc (master_acc),
            .lead       (phase_off[i*W +: W]),
            .load       (load_en[i]),
            .st         (slv[i])
        );

        xpwm_xor_comb u_comb (
            .master_acc (master_acc),
            .st         (slv[i]),
            .pwm        (pwm_out[i])
        );

        // R7
        idle_low_chk: assert property (@(posedge clk) disable iff (rst)
            !slv[i].armed |-> !pwm_out[i]);

        // R6
        zero_lead_low_chk: assert property (@(posedge clk) disable iff (rst)
            (load_en[i] && phase_off[i*W +: W] == '0) |=> !pwm_out[i]);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (pwm_out == '0 && !master_wave));

endmodule

// File: tb/xpwm_gen_test.sv
module xpwm_gen_test;
    localparam int NCH = 4;
    localparam logic [31:0] INC = 32'h0100_0000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [31:0]        freq_inc = INC;
    logic [NCH*32-1:0]  phase_off = '0;
    logic [NCH-1:0]     load_en = '0;
    logic [NCH-1:0]     pwm_out;
    logic               master_wave;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    xpwm_gen #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst(rst), .freq_inc(freq_inc), .phase_off(phase_off),
        .load_en(load_en), .pwm_out(pwm_out), .master_wave(master_wave)
    );

    always #10 clk = ~clk;

    // Behavioural phase model
    logic [31:0] m_ref = '0;
    logic [31:0] inc_ref = '0;
    logic [31:0] s_ref [NCH];
    bit   [NCH-1:0] on_ref = '0;
    bit   live = 1'b0;

    initial for (int i = 0; i < NCH; i++) s_ref[i] = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_ref = '0;
            inc_ref = freq_inc;
            on_ref = '0;
            for (int i = 0; i < NCH; i++) s_ref[i] = '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (load_en[i]) begin
                    s_ref[i] = m_ref + inc_ref + phase_off[i*32 +: 32];
                    on_ref[i] = 1'b1;
                end else begin
                    s_ref[i] = s_ref[i] + inc_ref;
                end
            end
            m_ref = m_ref + inc_ref;
        end
        live = 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live && !finished) begin
            logic [NCH-1:0] exp_pwm;
            for (int i = 0; i < NCH; i++)
                exp_pwm[i] = on_ref[i] & (m_ref[31] ^ s_ref[i][31]);
            chk(pwm_out === exp_pwm, "R5 per-cycle pwm", int'(pwm_out), int'(exp_pwm));
            chk(master_wave === m_ref[31], "R2 per-cycle master",
                int'(master_wave), int'(m_ref[31]));
        end
    end

    task automatic load_ch(input int ch, input logic [31:0] off);
        @(negedge clk);
        phase_off[ch*32 +: 32] = off;
        load_en = '0;
        load_en[ch] = 1'b1;
        @(negedge clk);
        load_en = '0;
    endtask

    task automatic count_high(input int ch, input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (ch < 0) cnt += int'(master_wave);
            else        cnt += int'(pwm_out[ch]);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pwm_out == '0, "R1 pwm low in reset", int'(pwm_out), 0);
        chk(master_wave == 1'b0, "R1 master low in reset", int'(master_wave), 0);
        rst = 1'b0;
        @(negedge clk);
        // R2: increment changes after reset ignored
        freq_inc = 32'h0300_0000;
        count_high(-1, 256, c);
        chk(c == 128, "R2 master half high", c, 128);
        // R7: unloaded channel stays low
        count_high(3, 256, c);
        chk(c == 0, "R7 unloaded low", c, 0);
        // R5: quarter offset gives 50%
        load_ch(0, 32'h4000_0000);
        count_high(0, 256, c);
        chk(c == 128, "R5 quarter lead", c, 128);
        // R6: zero offset low, half offset high
        load_ch(1, 32'h0000_0000);
        count_high(1, 256, c);
        chk(c == 0, "R6 zero lead", c, 0);
        load_ch(2, 32'h8000_0000);
        count_high(2, 256, c);
        chk(c == 256, "R6 half lead", c, 256);
        // R5: one-clock lead
        load_ch(3, INC);
        count_high(3, 256, c);
        chk(c == 2, "R5 one clock lead", c, 2);
        // R9: reload while running
        load_ch(0, INC * 127);
        count_high(0, 256, c);
        chk(c == 254, "R9 reload 127 clocks", c, 254);
        // R8: other channels untouched by ch0 reload
        count_high(1, 256, c);
        chk(c == 0, "R8 ch1 unchanged", c, 0);
        count_high(2, 256, c);
        chk(c == 256, "R8 ch2 unchanged", c, 256);
        // R5: lead beyond half period is symmetric
        load_ch(0, 32'hC000_0000);
        count_high(0, 256, c);
        chk(c == 128, "R5 three-quarter lead", c, 128);
        // R3: output follows new offset in cycle after load edge
        load_ch(1, 32'h8000_0000);
        chk(pwm_out[1] == 1'b1, "R3 immediate response", int'(pwm_out[1]), 1);
        // R4: waveform persists without intervention
        repeat (1000) @(negedge clk);
        count_high(1, 256, c);
        chk(c == 256, "R4 autonomous hold", c, 256);
        count_high(3, 256, c);
        chk(c == 2, "R4 ch3 hold", c, 2);
        finished = 1'b1;
        report();
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
        end
    end
endmodule